// File: doc/BRIEF.md
# Programmable Delay Sweep Measurement Controller

This block works out the propagation delay of an external device by sweeping a delay code. Two external programmable delay lines are fired by one shared trigger. The launch line drives the device under test, and the capture line clocks a sampling flip-flop. That flip-flop samples the device's output edge. The controller keeps the launch line at its minimum setting. It moves an 11-bit capture code and reads back the sampled bit after each trigger. A high sample means the capture delay is longer than the device delay. A low sample means it is shorter.

The search is a binary search, one trial per bit, starting from the most significant bit. A dither check then repeats the trial at the final code. When that check sees both sample values, the capture edge sits on the device edge and the controller declares lock. When the check sees only one value, the code moves one step toward the edge and the check repeats. After too many failed checks the controller gives up and flags an error. The capture code is split across two cascaded lines. The low ten bits set the fine line. The top bit switches the coarse line between its minimum and maximum settings.

The result fields are plain status, not a stream. `done` is a single-cycle pulse and is not held waiting for an acknowledge. `code`, `result_ps`, `locked` and `err` stay stable until the next accepted `start`, so a consumer cannot stall the block and there is no back-pressure.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: After reset the block is idle with `busy`, `done`, `trig`, `locked` and `err` low, `code` at 0, and `launch_min` high.
- R2: `launch_min` is high at all times. `fine_code` equals `code[9:0]`. `coarse_max` equals `code[10]`, and `coarse_min` is its inverse.
- R3: A measurement starts on `start` while idle. The first trial uses code 1024. Each trial is exactly one single-cycle `trig` pulse. After a code change, `trig` is held off for at least `settle_cycles`+1 cycles.
- R4: In the search, each trial tests one bit, working from bit 10 down to bit 0. A high sample clears the bit under test and a low sample keeps it. The next trial then sets the next lower bit.
- R5: After bit 0, eight trials are made at the final code. If they contain both high and low samples, `done` pulses for one cycle with `locked` high, and `code` holds the locked value.
- R6: A dither check that sees only low samples raises the code by 1, and one that sees only high samples lowers it by 1. The code saturates at 0 and 2047. Every code change after the search is therefore exactly ±1.
- R7: On the 16th failed dither check, `done` pulses with `err` high and `locked` low, and the code is left unchanged. With no lock, this takes 139 trials in total (11 + 16×8).
- R8: `result_ps` equals 4400 + 10×`code` (16 bits) while `done` is high.
- R9: `start` while `busy` is high is ignored. The running measurement continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (accepted only while idle) |
| settle_cycles | input | 16 | Wait after a code change before triggering |
| sample_in | input | 1 | Asynchronous sampled bit from the external flip-flop |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Last measurement found the edge |
| err | output | 1 | Last measurement gave up |
| code | output | 11 | Current capture code |
| fine_code | output | 10 | Setting for the fine capture line |
| coarse_max | output | 1 | Coarse capture line at maximum |
| coarse_min | output | 1 | Coarse capture line at minimum |
| launch_min | output | 1 | Launch line held at minimum |
| trig | output | 1 | Fire both delay lines |
| result_ps | output | 16 | Delay in picoseconds for `code` |

## Verification
The bench targets transition points at both ends of the code range (0 and 2047) and on either side of the coarse-line switch (1023 and 1024). A design with a broken saturation or a wrong bit order would settle one step off, or wrap around, at these points.

It also models a device whose edge never dithers, with the edge placed mid-range, above the range, and at zero. There the controller must give up after exactly 139 trials. It must not lock on a pair of neighbouring codes or oscillate forever, and it must not wrap past the code limits.

Other checks cover the settle hold-off before every trigger, single-step moves after the search, and a second `start` during a run. A design that restarted on that second `start` would show a different trial count.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_TRIG,
    ST_WAIT,
    ST_DECIDE
  } dsc_state_e;
endpackage

// File: rtl/dsc_timer.sv
module dsc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] cnt;

  assign reached = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!reached) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsc_ps_conv.sv
module dsc_ps_conv #(
  parameter int CODE_W    = 11,
  parameter int RES_W     = 16,
  parameter int OFFSET_PS = 4400,
  parameter int STEP_PS   = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [RES_W-1:0]  ps
);
  assign ps = RES_W'(OFFSET_PS) + RES_W'(STEP_PS) * RES_W'(code);
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl #(
  parameter int CODE_W      = 11,
  parameter int CNT_W       = 16,
  parameter int RES_W       = 16,
  parameter int DITHER_N    = 8,
  parameter int MAX_FAIL    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int OFFSET_PS   = 4400,
  parameter int STEP_PS     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic              sample_in,
  output logic              busy,
  output logic              done,
  output logic              locked,
  output logic              err,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-2:0] fine_code,
  output logic              coarse_max,
  output logic              coarse_min,
  output logic              launch_min,
  output logic              trig,
  output logic [RES_W-1:0]  result_ps
);
  import dsc_pkg::*;

  localparam int IDX_W  = $clog2(CODE_W);
  localparam int DCNT_W = $clog2(DITHER_N + 1);
  localparam int FAIL_W = $clog2(MAX_FAIL + 1);
  localparam int LAT    = SYNC_STAGES + 1;
  localparam logic [CODE_W-1:0] MSB_ONE  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  dsc_state_e         state;
  logic [IDX_W-1:0]   bit_idx;
  logic [DCNT_W-1:0]  dcnt;
  logic [FAIL_W-1:0]  fails;
  logic               searching;
  logic               seen_hi, seen_lo;
  logic               hi_n, lo_n, last_trial;
  logic               smp;
  logic               settle_done, wait_done;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sample_in), .q(smp)
  );

  dsc_timer #(.W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SETTLE),
    .limit(settle_cycles), .reached(settle_done)
  );

  dsc_timer #(.W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT),
    .limit(CNT_W'(LAT - 1)), .reached(wait_done)
  );

  dsc_ps_conv #(
    .CODE_W(CODE_W), .RES_W(RES_W), .OFFSET_PS(OFFSET_PS), .STEP_PS(STEP_PS)
  ) u_conv (
    .code(code), .ps(result_ps)
  );

  always_comb begin
    hi_n       = seen_hi | smp;
    lo_n       = seen_lo | ~smp;
    last_trial = (dcnt == DCNT_W'(DITHER_N - 1));
  end

  assign busy       = (state != ST_IDLE);
  assign trig       = (state == ST_TRIG);
  assign fine_code  = code[CODE_W-2:0];
  assign coarse_max = code[CODE_W-1];
  assign coarse_min = ~code[CODE_W-1];
  assign launch_min = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      code      <= '0;
      bit_idx   <= '0;
      dcnt      <= '0;
      fails     <= '0;
      searching <= 1'b0;
      seen_hi   <= 1'b0;
      seen_lo   <= 1'b0;
      done      <= 1'b0;
      locked    <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          code      <= MSB_ONE;
          bit_idx   <= IDX_W'(CODE_W - 1);
          searching <= 1'b1;
          dcnt      <= '0;
          fails     <= '0;
          seen_hi   <= 1'b0;
          seen_lo   <= 1'b0;
          locked    <= 1'b0;
          err       <= 1'b0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) state <= ST_TRIG;
        ST_TRIG:   state <= ST_WAIT;
        ST_WAIT:   if (wait_done) state <= ST_DECIDE;
        ST_DECIDE: begin
          state <= ST_SETTLE;
          if (searching) begin
            if (smp) code[bit_idx] <= 1'b0;
            if (bit_idx == '0) begin
              searching <= 1'b0;
              dcnt      <= '0;
              seen_hi   <= 1'b0;
              seen_lo   <= 1'b0;
            end else begin
              code[bit_idx - 1'b1] <= 1'b1;
              bit_idx              <= bit_idx - 1'b1;
            end
          end else if (!last_trial) begin
            seen_hi <= hi_n;
            seen_lo <= lo_n;
            dcnt    <= dcnt + 1'b1;
          end else if (hi_n && lo_n) begin
            locked <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (fails == FAIL_W'(MAX_FAIL - 1)) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            fails   <= fails + 1'b1;
            dcnt    <= '0;
            seen_hi <= 1'b0;
            seen_lo <= 1'b0;
            if (lo_n && code != CODE_TOP)   code <= code + 1'b1;
            else if (hi_n && code != '0)    code <= code - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int CODE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              locked,
  input logic              err,
  input logic              trig,
  input logic [CODE_W-1:0] code
);
  a_r3_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r3_code_steady_at_trig: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $stable(code));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (locked ^ err));

  a_r9_idle_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !trig);
endmodule

bind dly_sweep_ctrl dsc_checker #(.CODE_W(CODE_W)) u_dsc_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .locked(locked),
  .err(err), .trig(trig), .code(code)
);

// File: tb/tb_dly_sweep_ctrl.sv
module tb_dly_sweep_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] settle_cycles = 16'd0;
  logic        sample_in = 1'b0;
  logic        busy, done, locked, err, coarse_max, coarse_min, launch_min, trig;
  logic [10:0] code;
  logic [9:0]  fine_code;
  logic [15:0] result_ps;

  always #5 clk = ~clk;

  dly_sweep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .sample_in(sample_in), .busy(busy), .done(done), .locked(locked), .err(err),
    .code(code), .fine_code(fine_code), .coarse_max(coarse_max),
    .coarse_min(coarse_min), .launch_min(launch_min), .trig(trig),
    .result_ps(result_ps)
  );

  // {edge T[12], dither 1, settle 8, exp_lock 1, exp_err 1, exp_code 11, exp_trigs 10}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {12'd700,  1'b1, 8'd2, 1'b1, 1'b0, 11'd700,  10'd0},
    {12'd0,    1'b1, 8'd0, 1'b1, 1'b0, 11'd0,    10'd0},
    {12'd2047, 1'b1, 8'd3, 1'b1, 1'b0, 11'd2047, 10'd0},
    {12'd1024, 1'b1, 8'd0, 1'b1, 1'b0, 11'd1024, 10'd0},
    {12'd1023, 1'b1, 8'd5, 1'b1, 1'b0, 11'd1023, 10'd0},
    {12'd300,  1'b0, 8'd1, 1'b0, 1'b1, 11'd300,  10'd139},
    {12'd4095, 1'b0, 8'd0, 1'b0, 1'b1, 11'd2047, 10'd139},
    {12'd0,    1'b0, 8'd2, 1'b0, 1'b1, 11'd0,    10'd139}
  };

  int n_checks = 0;
  int n_fail   = 0;

  // external model state
  int   edge_t = 0;
  logic dith   = 1'b0;
  logic tog    = 1'b0;

  // monitor state
  int   trigs = 0, first_code = -1, second_code = -1, since = 0, prev_code = 0;
  int   v2 = 0, v3 = 0, v6 = 0;
  int   settle_cur = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // flip-flop and device model: high when capture code is past the edge
  always @(posedge clk) begin
    if (trig) begin
      if (int'(code) > edge_t)       sample_in <= 1'b1;
      else if (int'(code) < edge_t)  sample_in <= 1'b0;
      else                           sample_in <= dith ? tog : 1'b1;
      tog <= ~tog;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(code) != prev_code) begin
        if (trigs >= 11 && (int'(code) - prev_code != 1) && (prev_code - int'(code) != 1))
          v6++;
        since = 0;
      end else begin
        since++;
      end
      prev_code = int'(code);
      if (trig) begin
        trigs++;
        if (trigs == 1) first_code = int'(code);
        if (trigs == 2) second_code = int'(code);
        if (since < settle_cur + 1) v3++;
        if (!launch_min || fine_code != code[9:0] || coarse_max != code[10] ||
            coarse_min != ~code[10]) v2++;
      end
    end
  end

  task automatic run_case(input int t, input logic d, input int s, input bit poke,
                          output int n_trig, output logic lk, output logic er,
                          output int cd, output int ps);
    int wd;
    edge_t = t; dith = d; tog = 1'b0;
    settle_cur = s; settle_cycles = 16'(s);
    trigs = 0; first_code = -1; second_code = -1; v2 = 0; v3 = 0; v6 = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
      if (poke && (wd == 30 || wd == 200)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done == 1'b1, "watchdog", wd, 20000);
    n_trig = trigs; lk = locked; er = err; cd = int'(code); ps = int'(result_ps);
  endtask

  initial begin
    int ntr, cd, ps, ref_trigs, exp_second, hi1;
    logic lk, er;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !trig && !locked && !err, "R1 idle flags", busy, 0);
    chk(code == 11'd0, "R1 code", int'(code), 0);
    chk(launch_min == 1'b1, "R1/R2 launch_min", launch_min, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !trig, "R1 idle after release", busy, 0);

    for (int i = 0; i < NV; i++) begin
      int vt, vs, vc, vn;
      logic vd, vl, ve;
      vt = int'(VEC[i][43:32]); vd = VEC[i][31]; vs = int'(VEC[i][30:23]);
      vl = VEC[i][22]; ve = VEC[i][21]; vc = int'(VEC[i][20:10]); vn = int'(VEC[i][9:0]);
      run_case(vt, vd, vs, 1'b0, ntr, lk, er, cd, ps);
      chk(lk == vl, "R5 locked", lk, vl);
      chk(er == ve, "R7 err", er, ve);
      chk(cd == vc, "R5/R6 final code", cd, vc);
      chk(ps == 4400 + 10 * vc, "R8 result_ps", ps, 4400 + 10 * vc);
      chk(first_code == 1024, "R3 first trial code", first_code, 1024);
      hi1 = (1024 > vt || (1024 == vt && !vd)) ? 1 : 0;
      exp_second = hi1 ? 512 : 1536;
      chk(second_code == exp_second, "R4 second trial code", second_code, exp_second);
      chk(v2 == 0, "R2 line controls", v2, 0);
      chk(v3 == 0, "R3 settle hold-off", v3, 0);
      chk(v6 == 0, "R6 single steps", v6, 0);
      if (vn != 0) chk(ntr == vn, "R7 trial count", ntr, vn);
      else chk(ntr >= 19 && (ntr - 11) % 8 == 0, "R5 dither trial count", ntr, 19);
      @(negedge clk);
      chk(!done && !busy, "R5 done is one pulse", done, 0);
    end

    // R9: start while busy is ignored
    run_case(700, 1'b1, 2, 1'b0, ref_trigs, lk, er, cd, ps);
    run_case(700, 1'b1, 2, 1'b1, ntr, lk, er, cd, ps);
    chk(ntr == ref_trigs, "R9 trial count with extra start", ntr, ref_trigs);
    chk(lk && cd == 700, "R9 result with extra start", cd, 700);

    // R1: reset mid-run returns to idle
    edge_t = 900; dith = 1'b1; settle_cycles = 16'd4;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !trig && code == 11'd0 && !locked, "R1 reset mid-run", int'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule